// File: doc/BRIEF.md
# Delayed-Sample Event Formatter

This block sits on one digitizer channel. Each strobe brings in a 10-bit sample, which goes into a programmable delay buffer. The delay lets a late trigger still reach the samples that came before it. When a trigger is accepted, the block writes a header word to a 16-bit FIFO write port. It then looks at the next `cfg_nsamp` delayed samples. For each sample at or above the channel threshold it writes an ADC word and then a time word. A trailer word closes the event and gives the number of samples kept.

Every output word carries a 3-bit type code and a check bit. The check bit makes the parity of the whole word even. The module number, channel number, threshold, window length and delay are held static while an event is in progress. The block runs on a system clock faster than the sample rate, and sample strobes are at least two clocks apart.

Top module: `dly_evt_fmt`

## Requirements
- R1: The value in an ADC word is the sample that arrived `cfg_delay` strobes before the strobe that produced it. A delay of 0 uses the current sample. The largest delay is 127.
- R2: A header word is {check, 3'b001, 1'b0, cfg_module[5:0], cfg_chan[4:0]}. It is written in the clock after the trigger is accepted.
- R3: An ADC word is {check, 3'b010, 2'b00, value[9:0]}. It is written only for window samples whose value is at least `cfg_thresh`. Samples below the threshold produce no words.
- R4: A time word is {check, 3'b011, 2'b00, bin[9:0]}. It follows its ADC word in the very next clock. `bin` is the 0-based index of the sample within the window.
- R5: The trailer is {check, 3'b100, 2'b00, count[9:0]}, where count is the number of ADC words written in the event. It is the last word of the event, and `busy` falls with it.
- R6: The window is the `cfg_nsamp` strobes that follow the trigger's clock edge. With `cfg_nsamp` = 0, the trailer comes straight after the header. Strobes are never on adjacent clocks.
- R7: Bit 15 of every written word makes the XOR of all 16 bits zero.
- R8: No word is written in the clock after `fifo_full` was sampled high. When a data word meets a full FIFO, the rest of the event's data words are dropped. The trailer waits for space and still counts only the ADC words actually written.
- R9: A trigger is ignored while `busy` is high, or when `fifo_full` is high at the trigger edge.
- R10: After reset, `fifo_wr` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 10 | Sample value |
| trig | input | 1 | Trigger pulse |
| cfg_module | input | 6 | Module number placed in the header |
| cfg_chan | input | 5 | Channel number placed in the header |
| cfg_thresh | input | 10 | Zero-suppression threshold |
| cfg_nsamp | input | 10 | Window length in samples |
| cfg_delay | input | 7 | Delay in strobes |
| fifo_full | input | 1 | FIFO cannot take a word |
| fifo_wr | output | 1 | FIFO write enable |
| fifo_din | output | 16 | FIFO write data |
| busy | output | 1 | Event in progress |

## Verification
The hardest case to reach is the full-FIFO cut-off in the middle of an event. Here an ADC/time pair stops partway through the window, the trailer stalls, and the count must match only the words that got out. The bench raises `fifo_full` on the idle clock just before a chosen window strobe and releases it after the window. It repeats this with the threshold at zero and with a threshold that skips some samples, so the stop can fall on a sample that is kept or one that is not. Long delays of up to 127 strobes need a warm-up of more than 128 strobes, so every delayed read returns real history.

// File: rtl/dly_evt_fmt.sv
module dly_evt_fmt #(
  parameter int SW    = 10,
  parameter int DEPTH = 128,
  parameter int BW    = 10,
  parameter int MW    = 6,
  parameter int CW    = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_vld,
  input  logic [SW-1:0]            smp_data,
  input  logic                     trig,
  input  logic [MW-1:0]            cfg_module,
  input  logic [CW-1:0]            cfg_chan,
  input  logic [SW-1:0]            cfg_thresh,
  input  logic [BW-1:0]            cfg_nsamp,
  input  logic [$clog2(DEPTH)-1:0] cfg_delay,
  input  logic                     fifo_full,
  output logic                     fifo_wr,
  output logic [15:0]              fifo_din,
  output logic                     busy
);
  localparam int DW = $clog2(DEPTH);
  localparam int PW = 12;
  localparam logic [2:0] T_HDR = 3'b001, T_ADC = 3'b010, T_TIM = 3'b011, T_TRL = 3'b100;

  typedef enum logic [1:0] {S_IDLE, S_CAPT, S_TRL} st_t;

  st_t            st;
  logic [SW-1:0]  mem [DEPTH];
  logic [DW-1:0]  wp;
  logic [BW-1:0]  bin, tbin, nkept;
  logic           tpend, stop;

  wire [SW-1:0] dly  = (cfg_delay == '0) ? smp_data : mem[wp - cfg_delay];
  wire          last = (bin == cfg_nsamp - BW'(1));
  wire          keep = (dly >= cfg_thresh);

  function automatic logic [15:0] mkword(input logic [2:0] t, input logic [PW-1:0] p);
    return {^{t, p}, t, p};
  endfunction

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      wp       <= '0;
      bin      <= '0;
      tbin     <= '0;
      nkept    <= '0;
      tpend    <= 1'b0;
      stop     <= 1'b0;
      fifo_wr  <= 1'b0;
      fifo_din <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      fifo_wr <= 1'b0;
      if (smp_vld) begin
        mem[wp] <= smp_data;
        wp      <= wp + DW'(1);
      end
      case (st)
        S_IDLE: begin
          if (trig && !fifo_full) begin
            fifo_wr  <= 1'b1;
            fifo_din <= mkword(T_HDR, {1'b0, cfg_module, cfg_chan});
            bin      <= '0;
            nkept    <= '0;
            tpend    <= 1'b0;
            stop     <= 1'b0;
            st       <= (cfg_nsamp == '0) ? S_TRL : S_CAPT;
          end
        end
        default: begin
          if (tpend) begin
            tpend <= 1'b0;
            if (!fifo_full && !stop) begin
              fifo_wr  <= 1'b1;
              fifo_din <= mkword(T_TIM, PW'(tbin));
            end else begin
              stop <= 1'b1;
            end
          end else if (st == S_TRL && !fifo_full) begin
            fifo_wr  <= 1'b1;
            fifo_din <= mkword(T_TRL, PW'(nkept));
            st       <= S_IDLE;
          end
          if (st == S_CAPT && smp_vld) begin
            bin <= bin + BW'(1);
            if (last) st <= S_TRL;
            if (keep) begin
              if (!fifo_full && !stop) begin
                fifo_wr  <= 1'b1;
                fifo_din <= mkword(T_ADC, PW'(dly));
                tpend    <= 1'b1;
                tbin     <= bin;
                nkept    <= nkept + BW'(1);
              end else begin
                stop <= 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (^fifo_din) == 1'b0); // R7
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !$past(fifo_full)); // R8
  AST_KEPT_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_din[14:12] == T_ADC) |-> fifo_din[SW-1:0] >= cfg_thresh); // R3
  AST_TIME_AFTER_ADC: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_din[14:12] == T_TIM) |-> ($past(fifo_wr) && $past(fifo_din[14:12]) == T_ADC)); // R4
  AST_HDR_OPENS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (fifo_wr && fifo_din[14:12] == T_HDR)); // R2
  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> !smp_vld); // R6
endmodule

// File: tb/tb_dly_evt_fmt.sv
module tb_dly_evt_fmt;
  logic        clk = 0, rst_n = 0;
  logic        smp_vld = 0, trig = 0, fifo_full = 0;
  logic [9:0]  smp_data = '0, cfg_thresh = '0, cfg_nsamp = '0;
  logic [5:0]  cfg_module = 6'd37;
  logic [4:0]  cfg_chan = 5'd19;
  logic [6:0]  cfg_delay = '0;
  logic        fifo_wr, busy;
  logic [15:0] fifo_din;

  int nchk = 0, nfail = 0, gk = 0;
  logic [15:0] got[$];
  logic [15:0] exp_q[$];

  always #4 clk = ~clk;

  dly_evt_fmt dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data), .trig(trig),
    .cfg_module(cfg_module), .cfg_chan(cfg_chan), .cfg_thresh(cfg_thresh),
    .cfg_nsamp(cfg_nsamp), .cfg_delay(cfg_delay), .fifo_full(fifo_full),
    .fifo_wr(fifo_wr), .fifo_din(fifo_din), .busy(busy));

  always @(negedge clk) if (fifo_wr) got.push_back(fifo_din);

  function automatic logic [9:0] sval(input int k);
    return 10'((k * 97 + 13) % 1024);
  endfunction

  function automatic logic [15:0] mk(input logic [2:0] t, input logic [11:0] p);
    return {^{t, p}, t, p};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk); smp_vld = 1; smp_data = sval(gk); gk++;
    @(negedge clk); smp_vld = 0;
    @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
  endtask

  task automatic run_event(input int d, input int thr, input int n, input int fullat, input bit retrig);
    int k0, cnt;
    string tag;
    cfg_delay = 7'(d); cfg_thresh = 10'(thr); cfg_nsamp = 10'(n);
    got.delete(); exp_q.delete();
    pulse_trig();
    k0 = gk;
    for (int i = 0; i < n; i++) begin
      if (i == fullat) fifo_full = 1;
      if (retrig && i == 1) pulse_trig();
      strobe();
    end
    repeat (3) @(negedge clk);
    fifo_full = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    exp_q.push_back(mk(3'b001, {1'b0, cfg_module, cfg_chan}));
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      logic [9:0] v;
      if (fullat >= 0 && i >= fullat) break;
      v = sval(k0 + i - d);
      if (v >= 10'(thr)) begin
        exp_q.push_back(mk(3'b010, {2'b00, v}));
        exp_q.push_back(mk(3'b011, {2'b00, 10'(i)}));
        cnt++;
      end
    end
    exp_q.push_back(mk(3'b100, {2'b00, 10'(cnt)}));
    tag = (fullat >= 0) ? "R8 word count" : (retrig ? "R9 word count" : "R6 word count");
    check(got.size() == exp_q.size(), tag, got.size(), exp_q.size());
    for (int j = 0; j < exp_q.size() && j < got.size(); j++) begin
      case (exp_q[j][14:12])
        3'b001:  tag = "R2 header";
        3'b010:  tag = "R1/R3 adc word";
        3'b011:  tag = "R4 time word";
        default: tag = (fullat >= 0) ? "R8 trailer" : "R5 trailer";
      endcase
      check(got[j] == exp_q[j], tag, got[j], exp_q[j]);
      check((^got[j]) == 1'b0, "R7 parity", got[j], exp_q[j]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int dl[5];
    int tl[3];
    int nl[4];
    dl = '{0, 1, 6, 31, 127};
    tl = '{0, 300, 1023};
    nl = '{0, 1, 5, 20};
    repeat (3) @(negedge clk);
    check(fifo_wr == 0, "R10 fifo_wr in reset", fifo_wr, 0);
    check(busy == 0, "R10 busy in reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    check(fifo_wr == 0 && busy == 0, "R10 idle after reset", {fifo_wr, busy}, 0);
    for (int i = 0; i < 130; i++) strobe();
    foreach (dl[a]) foreach (tl[b]) foreach (nl[c]) begin
      cfg_module = 6'(a * 9 + b + 1);
      cfg_chan   = 5'(c * 7 + 3);
      run_event(dl[a], tl[b], nl[c], -1, 0);
    end
    run_event(2, 0, 6, 0, 0);
    run_event(2, 0, 6, 3, 0);
    run_event(5, 600, 10, 4, 0);
    run_event(0, 0, 8, 7, 0);
    run_event(3, 200, 6, -1, 1);
    got.delete();
    fifo_full = 1;
    pulse_trig();
    repeat (4) @(negedge clk);
    check(busy == 0, "R9 trigger while full busy", busy, 0);
    check(got.size() == 0, "R9 trigger while full writes", got.size(), 0);
    fifo_full = 0;
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule